// File: doc/BRIEF.md
# Multi-Channel Transmit Packet-Available Poll Responder

This block sits on the PHY side of a packet transmit interface that serves one or more channels. The FIFO fill logic supplies a vector with one "space available" bit per channel. The link layer reads this status in one of three ways, and the `MODE` parameter picks which one when the block is built.

In the two polled modes the link layer drives an address onto a transmit address bus every clock. The block compares that address with a base address window. If the address falls inside the window, the block returns the status bit of the matching channel on a registered polled flag, together with an output-enable. The link layer can also name a channel by raising a select strobe with an in-window address. The block then reports the status of that chosen channel on a separate selected flag, every clock, until a new channel is chosen. The reduced polled mode leaves the selected flag out. In direct mode the block does no address matching at all. It presents one registered flag per channel. An output-enable flag takes the place of bus tri-stating.

Top module: `pa_poll_responder`

## Requirements
- R1: While reset is applied, and for the cycles after reset until the first stimulus, `poll_pa`, `poll_pa_oe`, `sel_pa` and `direct_pa` are all 0.
- R2: In the polled modes (`MODE` 1 = polled, 2 = polled without selected flag), an address sampled at a clock edge that lies inside the window sets `poll_pa_oe` to 1 and sets `poll_pa` to `space_ok[poll_addr - base_addr]` after that same edge, which is one clock of latency.
- R3: An address outside the window, whether below it, above it, or reached by wrap-around of the address bus, sets both `poll_pa_oe` and `poll_pa` to 0 after the edge at which it is sampled.
- R4: The window holds the addresses `base_addr` through `base_addr + NUM_CH - 1`, computed without modular wrap. A single-channel instance therefore answers only at `base_addr`.
- R5: In mode 1, a clock edge at which `sel_strobe` is 1 and the address is inside the window selects channel `poll_addr - base_addr`. After every later edge, `sel_pa` equals that channel's `space_ok` bit as sampled at the edge. A strobe with an out-of-window address leaves the selection unchanged.
- R6: In mode 1, `sel_pa` stays 0 until the first valid selection.
- R7: In mode 2, `sel_pa` is always 0, while `poll_pa` and `poll_pa_oe` behave as in R2 to R4.
- R8: In mode 0 (direct), `direct_pa[i]` equals `space_ok[i]` one clock later. `poll_addr`, `base_addr` and `sel_strobe` are ignored, and `poll_pa`, `poll_pa_oe` and `sel_pa` stay 0.
- R9: In the polled modes, `direct_pa` stays 0.
- R10: A change of `base_addr` takes effect at the first edge that samples the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| base_addr | input | ADDR_W | Base of the address window |
| poll_addr | input | ADDR_W | Transmit address bus driven by the link layer |
| sel_strobe | input | 1 | Marks the current address as a channel selection |
| space_ok | input | NUM_CH | Per-channel space-available status from the FIFO fill logic |
| poll_pa | output | 1 | Registered packet-available flag for the polled address |
| poll_pa_oe | output | 1 | High when `poll_pa` answers an in-window poll |
| sel_pa | output | 1 | Packet-available flag of the selected channel |
| direct_pa | output | NUM_CH | One registered packet-available flag per channel, used in direct mode |

## Verification
The polled flag and the selected flag share one address bus, so a single edge can both answer a poll and change the selection. The bench provokes this by raising `sel_strobe` with in-window addresses while `space_ok` changes in the same cycle. It also raises `sel_strobe` with out-of-window addresses, which must leave the selection alone. A behavioural model computes both flags from the same sampled inputs, and the bench compares them against all four instances every clock. The bench also moves the window to the top of the address range, so that wrap-around addresses must miss.

// File: rtl/pa_pkg.sv
package pa_pkg;

  // Reporting style chosen at build time
  typedef enum logic [1:0] {
    PA_DIRECT       = 2'd0,
    PA_POLLED       = 2'd1,
    PA_POLLED_NOSEL = 2'd2
  } pa_mode_e;

  // Width of a channel index; never below one bit
  function automatic int ch_idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pa_rst_sync.sv
module pa_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/pa_addr_window.sv
module pa_addr_window #(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] poll_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  localparam int DIFF_W = ADDR_W + 1;
  localparam logic [DIFF_W-1:0] SPAN = DIFF_W'(NUM_CH);

  logic [DIFF_W-1:0] diff;

  // One extra bit keeps addresses below the base from wrapping into range
  always_comb begin
    diff = {1'b0, poll_addr} - {1'b0, base_addr};
    hit  = !diff[ADDR_W] && (diff < SPAN);
    idx  = hit ? diff[IDX_W-1:0] : '0;
  end

endmodule

// File: rtl/pa_poll_flag.sv
module pa_poll_flag #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [NUM_CH-1:0] space_ok,
  output logic              poll_pa,
  output logic              poll_oe
);

  logic pick;
  logic pa_d;
  logic oe_d;
  logic pa_q;
  logic oe_q;

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (idx == IDX_W'(i)) pick = space_ok[i];
    end
  end

  always_comb begin
    oe_d = hit;
    pa_d = hit & pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      pa_q <= pa_d;
      oe_q <= oe_d;
    end
  end

  assign poll_pa = pa_q;
  assign poll_oe = oe_q;

  AST_HIT_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> poll_oe); // R2
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (!poll_oe && !poll_pa)); // R3

endmodule

// File: rtl/pa_sel_tracker.sv
module pa_sel_tracker #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [NUM_CH-1:0] space_ok,
  output logic              sel_pa
);

  logic             load;
  logic [IDX_W-1:0] sel_idx_d;
  logic [IDX_W-1:0] sel_idx_q;
  logic             vld_d;
  logic             vld_q;
  logic             pick;
  logic             pa_d;
  logic             pa_q;

  always_comb begin
    load      = strobe & hit;
    sel_idx_d = load ? idx : sel_idx_q;
    vld_d     = vld_q | load;
  end

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_idx_d == IDX_W'(i)) pick = space_ok[i];
    end
    pa_d = vld_d & pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx_q <= '0;
      vld_q     <= 1'b0;
      pa_q      <= 1'b0;
    end else begin
      sel_idx_q <= sel_idx_d;
      vld_q     <= vld_d;
      pa_q      <= pa_d;
    end
  end

  assign sel_pa = pa_q;

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe || !hit) |=> $stable(sel_idx_q)); // R5
  AST_UNSELECTED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> !sel_pa); // R6

endmodule

// File: rtl/pa_direct_flags.sv
module pa_direct_flags #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] space_ok,
  output logic [NUM_CH-1:0] direct_pa
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    logic flag_d;
    logic flag_q;

    always_comb begin
      flag_d = space_ok[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else begin
        flag_q <= flag_d;
      end
    end

    assign direct_pa[g] = flag_q;
  end

  AST_DIRECT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (direct_pa == $past(space_ok))); // R8

endmodule

// File: rtl/pa_poll_responder.sv
module pa_poll_responder #(
  parameter int               ADDR_W = 8,
  parameter int               NUM_CH = 4,
  parameter pa_pkg::pa_mode_e MODE   = pa_pkg::PA_POLLED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic              sel_strobe,
  input  logic [NUM_CH-1:0] space_ok,
  output logic              poll_pa,
  output logic              poll_pa_oe,
  output logic              sel_pa,
  output logic [NUM_CH-1:0] direct_pa
);

  localparam int IDX_W = pa_pkg::ch_idx_w(NUM_CH);

  logic rst_q_n;

  pa_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_q_n)
  );

  if (MODE == pa_pkg::PA_DIRECT) begin : g_direct
    pa_direct_flags #(.NUM_CH(NUM_CH)) u_flags (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .space_ok  (space_ok),
      .direct_pa (direct_pa)
    );
    assign poll_pa    = 1'b0;
    assign poll_pa_oe = 1'b0;
    assign sel_pa     = 1'b0;
  end else begin : g_polled
    logic             hit;
    logic [IDX_W-1:0] idx;

    pa_addr_window #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_win (
      .base_addr (base_addr),
      .poll_addr (poll_addr),
      .hit       (hit),
      .idx       (idx)
    );

    pa_poll_flag #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_poll (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .hit      (hit),
      .idx      (idx),
      .space_ok (space_ok),
      .poll_pa  (poll_pa),
      .poll_oe  (poll_pa_oe)
    );

    if (MODE == pa_pkg::PA_POLLED) begin : g_sel
      pa_sel_tracker #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_sel (
        .clk      (clk),
        .rst_n    (rst_q_n),
        .strobe   (sel_strobe),
        .hit      (hit),
        .idx      (idx),
        .space_ok (space_ok),
        .sel_pa   (sel_pa)
      );
    end else begin : g_nosel
      assign sel_pa = 1'b0;
    end

    assign direct_pa = '0;
  end

  AST_FLAG_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_q_n)
    poll_pa |-> poll_pa_oe); // R2

endmodule

// File: tb/pa_poll_responder_test.sv
module pa_poll_responder_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] base = 8'h10;
  logic [7:0] addr = 8'h00;
  logic       strb = 1'b0;
  logic [3:0] st = 4'h0;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  bit base_phase = 1'b0;

  always #2 clk = ~clk;

  logic       p_pa, p_oe, p_sel;
  logic [3:0] p_dir;
  logic       n_pa, n_oe, n_sel;
  logic [3:0] n_dir;
  logic       d_pa, d_oe, d_sel;
  logic [3:0] d_dir;
  logic       o_pa, o_oe, o_sel;
  logic [0:0] o_dir;

  pa_poll_responder #(.ADDR_W(8), .NUM_CH(4), .MODE(pa_pkg::PA_POLLED)) uut (
    .clk(clk), .rst_n(rst_n), .base_addr(base), .poll_addr(addr),
    .sel_strobe(strb), .space_ok(st),
    .poll_pa(p_pa), .poll_pa_oe(p_oe), .sel_pa(p_sel), .direct_pa(p_dir));

  pa_poll_responder #(.ADDR_W(8), .NUM_CH(4), .MODE(pa_pkg::PA_POLLED_NOSEL)) uut_nosel (
    .clk(clk), .rst_n(rst_n), .base_addr(base), .poll_addr(addr),
    .sel_strobe(strb), .space_ok(st),
    .poll_pa(n_pa), .poll_pa_oe(n_oe), .sel_pa(n_sel), .direct_pa(n_dir));

  pa_poll_responder #(.ADDR_W(8), .NUM_CH(4), .MODE(pa_pkg::PA_DIRECT)) uut_dir (
    .clk(clk), .rst_n(rst_n), .base_addr(base), .poll_addr(addr),
    .sel_strobe(strb), .space_ok(st),
    .poll_pa(d_pa), .poll_pa_oe(d_oe), .sel_pa(d_sel), .direct_pa(d_dir));

  pa_poll_responder #(.ADDR_W(8), .NUM_CH(1), .MODE(pa_pkg::PA_POLLED)) uut_one (
    .clk(clk), .rst_n(rst_n), .base_addr(base), .poll_addr(addr),
    .sel_strobe(strb), .space_ok(st[0:0]),
    .poll_pa(o_pa), .poll_pa_oe(o_oe), .sel_pa(o_sel), .direct_pa(o_dir));

  // Behavioural reference
  logic       e_pa, e_oe, e_sel, e1_pa, e1_oe, e1_sel, e_vld;
  logic [3:0] e_dir;
  int  m_sel, m1_sel;
  bit  m_vld, m1_vld;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_pa <= 0; e_oe <= 0; e_sel <= 0; e_dir <= 0; e_vld <= 0;
      e1_pa <= 0; e1_oe <= 0; e1_sel <= 0;
      m_vld = 0; m_sel = 0; m1_vld = 0; m1_sel = 0;
    end else begin
      int off;
      bit hit4, hit1;
      off  = int'(addr) - int'(base);
      hit4 = (off >= 0) && (off < 4);
      hit1 = (off == 0);
      e_oe <= hit4;
      e_pa <= hit4 ? st[off] : 1'b0;
      if (strb && hit4) begin m_sel = off; m_vld = 1; end
      e_sel <= m_vld ? st[m_sel] : 1'b0;
      e_vld <= m_vld;
      e1_oe <= hit1;
      e1_pa <= hit1 ? st[0] : 1'b0;
      if (strb && hit1) begin m1_sel = 0; m1_vld = 1; end
      e1_sel <= m1_vld ? st[0] : 1'b0;
      e_dir <= st;
    end
  end

  task automatic cmp(input string tag, input logic [3:0] act, input logic [3:0] exp);
    string t;
    t = (!rst_n) ? "R1" : tag;
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", t, $time, act, exp);
    end
  endtask

  task automatic check_all();
    string rp;
    rp = base_phase ? "R10" : "R2/R3 poll";
    cmp(rp, {3'b0, p_pa}, {3'b0, e_pa});
    cmp(rp, {3'b0, p_oe}, {3'b0, e_oe});
    cmp(e_vld ? "R5 sel" : "R6 sel", {3'b0, p_sel}, {3'b0, e_sel});
    cmp("R9 direct idle", p_dir, 4'h0);
    cmp("R7 poll", {2'b0, n_oe, n_pa}, {2'b0, e_oe, e_pa});
    cmp("R7 sel", {3'b0, n_sel}, 4'h0);
    cmp("R9 direct idle nosel", n_dir, 4'h0);
    cmp("R8 direct", d_dir, e_dir);
    cmp("R8 idle", {1'b0, d_sel, d_oe, d_pa}, 4'h0);
    cmp("R4 single", {1'b0, o_sel, o_oe, o_pa}, {1'b0, e1_sel, e1_oe, e1_pa});
    cmp("R9 direct idle single", {3'b0, o_dir}, 4'h0);
  endtask

  task automatic step(input logic [7:0] a, input logic s, input logic [3:0] v);
    @(negedge clk);
    check_all();
    addr = a; strb = s; st = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) begin @(negedge clk); check_all(); end      // R1 in reset
    rst_n = 1'b1;
    repeat (4) step(8'h00, 1'b0, 4'h0);                      // R1 after release
    // Sweep below, inside, above the window, base 0x10
    for (int a = 8'h0C; a <= 8'h16; a++) step(8'(a), 1'b0, 4'(a * 5));
    // Selection: in-window strobe, then status changes, then ignored strobe
    step(8'h12, 1'b1, 4'b0100);
    for (int k = 0; k < 6; k++) step(8'h20, 1'b0, 4'(k * 3));
    step(8'h30, 1'b1, 4'b1011);
    step(8'h05, 1'b0, 4'b0100);
    step(8'h10, 1'b1, 4'b0001);
    step(8'h13, 1'b0, 4'b1000);
    step(8'h13, 1'b0, 4'b0110);
    // Window at the top of the address range: wrapped addresses miss
    base = 8'hFE;
    for (int a = 0; a < 8; a++) step(8'(8'hFC + a), 1'(a & 1), 4'(15 - a));
    // Base change takes effect at once
    base_phase = 1'b1;
    base = 8'h40;
    step(8'h41, 1'b0, 4'b0010);
    step(8'h41, 1'b0, 4'b0010);
    base = 8'h41;
    step(8'h41, 1'b0, 4'b0001);
    step(8'h44, 1'b1, 4'b1000);
    step(8'h44, 1'b0, 4'b0000);
    base_phase = 1'b0;
    // Random traffic around the window
    base = 8'h80;
    for (int k = 0; k < 2000; k++) begin
      if (k % 250 == 0) base = 8'($urandom_range(0, 255));
      step(8'(base + 8'($urandom_range(0, 7)) - 8'd2), 1'($urandom_range(0, 3) == 0),
           4'($urandom_range(0, 15)));
    end
    step(8'h00, 1'b0, 4'h0);
    finish_run();
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule